// File: doc/BRIEF.md
# Store-and-Forward Packet Gate

This block sits in front of a packet consumer that cannot tolerate a pause once a packet has started. Words arriving on the streaming sink are written into an internal buffer together with their start and end markers. Nothing is offered on the streaming source until a complete packet, up to and including its end word, is held in the buffer. From then on the packet leaves with the valid signal held high every cycle until its end word has been taken.

A counter of complete packets sits beside the buffer. It goes up when an end word is written and goes down when an end word is sent, and the source presents data exactly while this counter is nonzero. Packets leave in arrival order. The buffer depth must cover the largest packet the system can produce; two or more such packets give better throughput.

Top module: `pkt_gate`

## Requirements
- R1: `in_ready` is high whenever fewer than DEPTH words are stored and low when DEPTH words are stored; after reset `in_ready` is 1 and `out_valid` is 0.
- R2: `out_valid` stays 0 while no complete packet is stored, and rises in the cycle after the clock edge that accepts the end word (`in_eop`=1) of a packet.
- R3: words leave in the order they were accepted, with `out_data`, `out_sop` and `out_eop` equal to the values of `in_data`, `in_sop` and `in_eop` at acceptance.
- R4: once the first word of a packet is presented, `out_valid` stays 1 every cycle until that packet's end word is taken (`out_valid` and `out_ready` both 1); while `out_ready` is 0 the presented word stays unchanged.
- R5: when an end word is written in the same cycle as another end word is sent, the count of complete packets is unchanged, so the following packet is presented in the next cycle without a gap.
- R6: after the last complete packet has been sent, `out_valid` returns to 0 and stays 0 while only a partial packet (no end word yet) is stored, even if other words are being written.
- R7: a packet of one word, with `sop` and `eop` both 1, is stored, released and sent like any other packet.
- R8: a packet of exactly DEPTH words is accepted in full, after which `in_ready` is 0, and it is then sent completely, after which `in_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sink word valid |
| in_ready | output | 1 | Sink can accept a word |
| in_sop | input | 1 | Sink word is the first of its packet |
| in_eop | input | 1 | Sink word is the last of its packet |
| in_data | input | DATA_W | Sink data |
| out_valid | output | 1 | Source word valid |
| out_ready | input | 1 | Downstream accepts the source word |
| out_sop | output | 1 | Source word is the first of its packet |
| out_eop | output | 1 | Source word is the last of its packet |
| out_data | output | DATA_W | Source data |

## Verification
The bench builds the gate with the default 64-bit data path and DEPTH set to 16, so that a full buffer and a packet of exactly the buffer depth are reached with a few dozen cycles of stimulus. The short depth also keeps the pointer wrap inside the exercised range, since the packets of the table and the directed tests together pass more than 16 words through the buffer. The overlap of an end-word write with an end-word send is set up deliberately, as is a partial packet waiting behind a complete one.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;

    // Output side: idle between packets, busy while a packet is leaving.
    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_BUSY = 1'b1
    } out_state_e;

    // Position of the markers inside a stored word: {sop, eop, data}.
    localparam int SOP_OFS = 1;
    localparam int EOP_OFS = 0;

endpackage

// File: rtl/pkt_gate_fifo.sv
module pkt_gate_fifo #(
    parameter  int W     = 66,
    parameter  int DEPTH = 256,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_word,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr_ptr = ptr_step(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = ptr_step(st_q.rd_ptr);
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr_ptr] <= push_word;
    end

    assign head  = mem[st_q.rd_ptr];
    assign count = st_q.count;
    assign full  = (st_q.count == CW'(DEPTH));

    // R1: no word is written into a full buffer
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.count != CW'(DEPTH)));

    // R3: no word is read from an empty buffer
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));

endmodule

// File: rtl/pkt_gate_credit.sv
module pkt_gate_credit #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] credits,
    output logic          avail
);

    typedef struct packed {
        logic [CW-1:0] credit;
    } credit_st_t;

    credit_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case ({inc, dec})
            2'b10:   st_d.credit = st_q.credit + 1'b1;
            2'b01:   st_d.credit = st_q.credit - 1'b1;
            default: st_d.credit = st_q.credit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign credits = st_q.credit;
    assign avail   = (st_q.credit != '0);

    // R5: an end word sent always has a stored complete packet behind it
    assert_credit_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (st_q.credit != '0));

    // R5: simultaneous add and remove leaves the packet count unchanged
    assert_credit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(credits));

endmodule

// File: rtl/pkt_gate_out.sv
module pkt_gate_out
    import pkt_gate_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          avail,
    input  logic          head_sop,
    input  logic          head_eop,
    input  logic [DW-1:0] head_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [DW-1:0] out_data,
    output logic          pop,
    output logic          eop_sent
);

    typedef struct packed {
        out_state_e state;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.state = head_eop ? OUT_IDLE : OUT_BUSY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: OUT_IDLE};
        else        st_q <= st_d;
    end

    // A stored complete packet stays counted until its end word leaves,
    // so the head word is valid without a gap for the whole packet.
    assign out_valid = avail;
    assign out_sop   = head_sop;
    assign out_eop   = head_eop;
    assign out_data  = head_data;
    assign pop       = avail && out_ready;
    assign eop_sent  = pop && head_eop;

    // R4: valid never drops between the first and the last word
    assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == OUT_BUSY) |-> out_valid);

    // R4: a stalled word is held unchanged
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sop) && $stable(out_eop)));

endmodule

// File: rtl/pkt_gate.sv
module pkt_gate
    import pkt_gate_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);

    localparam int WORD_W = DATA_W + 2;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              push, pop, full, eop_sent, avail;
    logic [WORD_W-1:0] push_word, head;
    logic [CW-1:0]     word_count, credits;

    assign push      = in_valid && in_ready;
    assign push_word = {in_sop, in_eop, in_data};
    assign in_ready  = !full;

    pkt_gate_fifo #(
        .W     (WORD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head      (head),
        .count     (word_count),
        .full      (full)
    );

    pkt_gate_credit #(
        .CW (CW)
    ) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (push && in_eop),
        .dec     (eop_sent),
        .credits (credits),
        .avail   (avail)
    );

    pkt_gate_out #(
        .DW (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail     (avail),
        .head_sop  (head[DATA_W + SOP_OFS]),
        .head_eop  (head[DATA_W + EOP_OFS]),
        .head_data (head[DATA_W-1:0]),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data),
        .pop       (pop),
        .eop_sent  (eop_sent)
    );

    // R2: every counted packet has its words in the buffer
    assert_credit_le_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
        credits <= word_count);

    // R2: the source is offered data only with a stored end word behind it
    assert_hold_until_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == '0) |-> !out_valid);

endmodule

// File: tb/tb_pkt_gate.sv
`timescale 1ns/1ps
module tb_pkt_gate;

    localparam int DW    = 64;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_sop, in_eop, out_ready;
    logic [DW-1:0] in_data;
    logic          in_ready, out_valid, out_sop, out_eop;
    logic [DW-1:0] out_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pkt_gate #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data)
    );

    // Table: packet lengths and first data value of each packet.
    localparam int          NPKT = 5;
    localparam int          LEN  [NPKT] = '{1, 2, 5, 8, 3};
    localparam logic [63:0] BASE [NPKT] = '{64'h1111_0000_0000_0100,
                                            64'h2222_0000_0000_0200,
                                            64'h3333_0000_0000_0300,
                                            64'h4444_0000_0000_0400,
                                            64'h5555_0000_0000_0500};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Enter and leave at a falling edge. Sends words first..last of a packet
    // of total length len; word i carries base+i.
    task automatic send_words(input logic [63:0] base, input int first, input int last,
                              input int len, input bit expect_idle);
        for (int i = first; i <= last; i++) begin
            if (expect_idle) chk("R2 out_valid before eop", {63'd0, out_valid}, 64'd0);
            chk("R1 in_ready with room", {63'd0, in_ready}, 64'd1);
            in_valid = 1'b1;
            in_data  = base + 64'(i);
            in_sop   = (i == 0);
            in_eop   = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic drain(input string req, input logic [63:0] base, input int first, input int len);
        for (int i = first; i < len; i++) begin
            chk("R4 out_valid during packet", {63'd0, out_valid}, 64'd1);
            chk({req, " data"}, out_data, base + 64'(i));
            chk({req, " sop"}, {63'd0, out_sop}, {63'd0, i == 0});
            chk({req, " eop"}, {63'd0, out_eop}, {63'd0, i == len - 1});
            out_ready = 1'b1;
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_sop    = 1'b0;
        in_eop    = 1'b0;
        in_data   = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
        chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: each packet held until complete, then drained.
        for (int p = 0; p < NPKT; p++) begin
            send_words(BASE[p], 0, LEN[p] - 1, LEN[p], 1'b1);
            chk("R2 out_valid after eop", {63'd0, out_valid}, 64'd1);
            drain("R3", BASE[p], 0, LEN[p]);
            chk("R6 idle after drain", {63'd0, out_valid}, 64'd0);
        end

        // R7: single-word packet
        send_words(64'h7777_0000_0000_0001, 0, 0, 1, 1'b1);
        chk("R7 single word released", {63'd0, out_valid}, 64'd1);
        chk("R7 single word sop", {63'd0, out_sop}, 64'd1);
        chk("R7 single word eop", {63'd0, out_eop}, 64'd1);
        drain("R7", 64'h7777_0000_0000_0001, 0, 1);
        chk("R7 idle after", {63'd0, out_valid}, 64'd0);

        // R4: stall in mid-packet
        send_words(64'h8888_0000_0000_0000, 0, 2, 3, 1'b1);
        chk("R4 data word 0", out_data, 64'h8888_0000_0000_0000);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R4 stall valid", {63'd0, out_valid}, 64'd1);
        chk("R4 stall data", out_data, 64'h8888_0000_0000_0001);
        @(negedge clk);
        chk("R4 stall valid held", {63'd0, out_valid}, 64'd1);
        chk("R4 stall data held", out_data, 64'h8888_0000_0000_0001);
        drain("R4", 64'h8888_0000_0000_0000, 1, 3);
        chk("R4 idle after", {63'd0, out_valid}, 64'd0);

        // R5: end-word write coincides with end-word send
        send_words(64'hAAAA_0000_0000_0000, 0, 1, 2, 1'b1);
        chk("R5 A word 0", out_data, 64'hAAAA_0000_0000_0000);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = 64'hBBBB_0000_0000_0000;
        in_sop    = 1'b1;
        in_eop    = 1'b0;
        @(negedge clk);
        chk("R5 A word 1", out_data, 64'hAAAA_0000_0000_0001);
        chk("R5 A eop", {63'd0, out_eop}, 64'd1);
        in_data = 64'hBBBB_0000_0000_0001;
        in_sop  = 1'b0;
        in_eop  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        chk("R5 next packet without gap", {63'd0, out_valid}, 64'd1);
        drain("R5", 64'hBBBB_0000_0000_0000, 0, 2);
        chk("R5 idle after", {63'd0, out_valid}, 64'd0);

        // R6: partial packet behind a complete one
        send_words(64'hCCCC_0000_0000_0000, 0, 1, 2, 1'b1);
        send_words(64'hDDDD_0000_0000_0000, 0, 1, 4, 1'b0);
        drain("R6", 64'hCCCC_0000_0000_0000, 0, 2);
        chk("R6 partial held", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        chk("R6 partial still held", {63'd0, out_valid}, 64'd0);
        send_words(64'hDDDD_0000_0000_0000, 2, 3, 4, 1'b1);
        chk("R6 released on eop", {63'd0, out_valid}, 64'd1);
        drain("R6", 64'hDDDD_0000_0000_0000, 0, 4);

        // R8: packet of exactly DEPTH words fills the buffer
        send_words(64'hEEEE_0000_0000_0000, 0, DEPTH - 1, DEPTH, 1'b1);
        chk("R8 R1 in_ready low when full", {63'd0, in_ready}, 64'd0);
        chk("R8 released", {63'd0, out_valid}, 64'd1);
        drain("R8", 64'hEEEE_0000_0000_0000, 0, DEPTH);
        chk("R8 in_ready back", {63'd0, in_ready}, 64'd1);
        chk("R8 idle after", {63'd0, out_valid}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule